// File: doc/BRIEF.md
# Reset-Selected Dual-Timing FIFO

This block is a single-clock FIFO whose read-side timing is fixed once per reset. On the first rising clock edge after the active-low reset is released, the block samples a mode-select input. That sampled value chooses one of two behaviours for the rest of the run. In standard mode, every word, including the first, leaves the FIFO only when it is requested with a read enable, and it appears on the read data output one cycle later. In fall-through mode, the oldest stored word is moved into an output register without any request, and a read enable acknowledges that word and consumes it.

The same two status outputs serve both modes, and their meaning depends on the mode. In standard mode, `rd_stat_o` is an active-low empty flag: it is low when the FIFO is empty and high when at least one word is stored. `wr_stat_o` is an active-low full flag: it is low when the FIFO is full. In fall-through mode, `rd_stat_o` is an active-high output-ready flag, and `wr_stat_o` is an active-high input-ready flag. Width and depth are parameters.

Top module: `modal_fifo`

## Requirements
- R1: The mode is taken from `mode_sel_i` on the first rising edge of `clk` after `rst_n` is high: 0 selects fall-through and 1 selects standard. Until that edge, both status outputs are 0 and any write or read is ignored.
- R2: Once the mode is taken, changes on `mode_sel_i` have no effect until the next reset.
- R3: In standard mode, `rd_data_o` changes only on the edge that follows a read enable sampled while `rd_stat_o` is 1. It then shows the oldest stored word, so words leave in write order, and the first word also needs a read. After reset `rd_data_o` is 0.
- R4: In standard mode, `rd_stat_o` is 1 exactly when at least one word is stored.
- R5: In standard mode, `wr_stat_o` is 0 exactly when DEPTH words are stored.
- R6: In fall-through mode, a word written into an empty FIFO appears on `rd_data_o`, with `rd_stat_o` going to 1, two edges after the write edge, without any read request.
- R7: In fall-through mode, a read enable while `rd_stat_o` is 1 consumes the presented word. The next stored word is presented after that same edge. If no word is stored, `rd_stat_o` falls to 0 instead. Without a read, the presented word and `rd_stat_o` hold.
- R8: In fall-through mode, `wr_stat_o` is 0 exactly when DEPTH words are stored behind the output register, so the FIFO holds up to DEPTH+1 words.
- R9: A read while no data is available and a write while `wr_stat_o` is 0 are both ignored and leave the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 1 | Timing-mode select, sampled once after reset (0 fall-through, 1 standard) |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | WIDTH | Write data |
| rd_en_i | input | 1 | Read request (standard) or acknowledge (fall-through) |
| rd_data_o | output | WIDTH | Read data |
| rd_stat_o | output | 1 | Empty flag, active low (standard) or output ready (fall-through) |
| wr_stat_o | output | 1 | Full flag, active low (standard) or input ready (fall-through) |

## Verification
The assertions assume that a requester may raise `wr_en_i` or `rd_en_i` at any time, including while the FIFO is full, while it is empty, or before the mode is taken. They also assume that `mode_sel_i` may change freely. The stimulus therefore leaves both enables and the select pin unconstrained and random. The random streams are biased per phase toward filling or toward draining, so that both flag boundaries are reached. A few directed phases cover a lone word written into an empty fall-through FIFO and writes attempted before the mode edge.

// File: rtl/modal_fifo_pkg.sv
package modal_fifo_pkg;
    typedef enum logic {
        MODE_FALL = 1'b0,
        MODE_STD  = 1'b1
    } tmode_e;
endpackage

// File: rtl/modal_fifo_mode.sv
module modal_fifo_mode
    import modal_fifo_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel_i,
    output logic   valid_o,
    output tmode_e mode_o
);
    typedef struct packed {
        logic   valid;
        tmode_e mode;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.valid) begin
            st_d.valid = 1'b1;
            st_d.mode  = tmode_e'(sel_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{valid: 1'b0, mode: MODE_STD};
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign mode_o  = st_q.mode;
endmodule

// File: rtl/modal_fifo_ptrs.sv
module modal_fifo_ptrs #(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    output logic [AW-1:0] wptr_o,
    output logic [AW-1:0] rptr_o,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
        logic [CW-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push_i) st_d.wp = (st_q.wp == AW'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (pop_i)  st_d.rp = (st_q.rp == AW'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        case ({push_i, pop_i})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wptr_o = st_q.wp;
    assign rptr_o = st_q.rp;
    assign cnt_o  = st_q.cnt;
endmodule

// File: rtl/modal_fifo_store.sv
module modal_fifo_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // Storage array carries no reset; only written entries are ever read.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/modal_fifo.sv
module modal_fifo
    import modal_fifo_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             rd_stat_o,
    output logic             wr_stat_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             vld;
    } out_t;

    logic             mode_vld;
    tmode_e           mode;
    logic             mode_std;
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt;
    logic [WIDTH-1:0] ram_rdata;
    logic             has_ram, ram_full;
    logic             push, std_pop, fw_take, fw_load, pop;
    out_t             out_d, out_q;

    modal_fifo_mode u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_i   (mode_sel_i),
        .valid_o (mode_vld),
        .mode_o  (mode)
    );

    modal_fifo_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (push),
        .pop_i  (pop),
        .wptr_o (wptr),
        .rptr_o (rptr),
        .cnt_o  (cnt)
    );

    modal_fifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .we_i    (push),
        .waddr_i (wptr),
        .wdata_i (wr_data_i),
        .raddr_i (rptr),
        .rdata_o (ram_rdata)
    );

    always_comb begin
        mode_std = (mode == MODE_STD);
        has_ram  = (cnt != '0);
        ram_full = (cnt == CW'(DEPTH));
        push     = mode_vld && wr_en_i && !ram_full;
        std_pop  = mode_vld && mode_std && rd_en_i && has_ram;
        fw_take  = mode_vld && !mode_std && rd_en_i && out_q.vld;
        fw_load  = mode_vld && !mode_std && has_ram && (!out_q.vld || fw_take);
        pop      = std_pop || fw_load;

        out_d = out_q;
        if (pop) begin
            out_d.data = ram_rdata;
            out_d.vld  = !mode_std;
        end else if (fw_take) begin
            out_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rd_data_o = out_q.data;
    assign rd_stat_o = mode_vld && (mode_std ? has_ram : out_q.vld);
    assign wr_stat_o = mode_vld && !ram_full;
endmodule

// File: rtl/modal_fifo_chk.sv
module modal_fifo_chk #(
    parameter int WIDTH = 32,
    parameter int AW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_vld,
    input logic             mode_std,
    input logic             wr_en,
    input logic             rd_en,
    input logic             rd_stat,
    input logic             wr_stat,
    input logic [WIDTH-1:0] rd_data,
    input logic [AW-1:0]    wptr,
    input logic [AW-1:0]    rptr
);
    AST_IDLE_BEFORE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_vld |-> (!rd_stat && !wr_stat)); // R1
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_vld && $past(mode_vld)) |-> (mode_std == $past(mode_std))); // R2
    AST_STD_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_vld && mode_std && !(rd_en && rd_stat)) |=> $stable(rd_data)); // R3
    AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_vld && !mode_std && rd_stat && !rd_en) |=> (rd_stat && $stable(rd_data))); // R7
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_vld && wr_en && !wr_stat) |=> $stable(wptr)); // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_vld && mode_std && rd_en && !rd_stat) |=> $stable(rptr)); // R9
endmodule

bind modal_fifo modal_fifo_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_vld (mode_vld),
    .mode_std (mode_std),
    .wr_en    (wr_en_i),
    .rd_en    (rd_en_i),
    .rd_stat  (rd_stat_o),
    .wr_stat  (wr_stat_o),
    .rd_data  (rd_data_o),
    .wptr     (wptr),
    .rptr     (rptr)
);

// File: tb/modal_fifo_tb.sv
module modal_fifo_tb;
    localparam int WIDTH = 32;
    localparam int DEPTH = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_sel_i = 1'b1;
    logic             wr_en_i = 1'b0;
    logic [WIDTH-1:0] wr_data_i = '0;
    logic             rd_en_i = 1'b0;
    logic [WIDTH-1:0] rd_data_o;
    logic             rd_stat_o;
    logic             wr_stat_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Bench model of the requirements
    logic             m_vld;
    logic             m_std;
    logic [WIDTH-1:0] m_q[$];
    logic [WIDTH-1:0] m_out;
    logic             m_ov;

    always #2.5 clk = ~clk;

    modal_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel_i (mode_sel_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_en_i    (rd_en_i),
        .rd_data_o  (rd_data_o),
        .rd_stat_o  (rd_stat_o),
        .wr_stat_o  (wr_stat_o)
    );

    task automatic chk(input bit ok, input string req, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic exp_rd_stat();
        if (!m_vld) return 1'b0;
        return m_std ? (m_q.size() > 0) : m_ov;
    endfunction

    function automatic logic exp_wr_stat();
        return m_vld && (m_q.size() < DEPTH);
    endfunction

    task automatic check_outputs();
        logic er, ew;
        er = exp_rd_stat();
        ew = exp_wr_stat();
        if (!m_vld) begin
            chk(rd_stat_o == 1'b0, "R1 rd_stat before mode", rd_stat_o, 0);
            chk(wr_stat_o == 1'b0, "R1 wr_stat before mode", wr_stat_o, 0);
        end else if (m_std) begin
            chk(rd_stat_o == er, "R4 empty flag", rd_stat_o, er);
            chk(wr_stat_o == ew, "R5 full flag", wr_stat_o, ew);
            chk(rd_data_o == m_out, "R3 standard data", rd_data_o, m_out);
        end else begin
            chk(rd_stat_o == er, "R7 output ready", rd_stat_o, er);
            chk(wr_stat_o == ew, "R8 input ready", wr_stat_o, ew);
            if (m_ov) chk(rd_data_o == m_out, "R6 R7 presented data", rd_data_o, m_out);
        end
    endtask

    // Advance the model by one edge given the inputs now driven
    task automatic model_step();
        bit push, load, take;
        if (!m_vld) begin
            m_vld = 1'b1;   // R1: writes and reads ignored this edge
            m_std = mode_sel_i;
            return;
        end
        // R2: mode_sel_i is ignored from here on; R9: guarded push/pop
        push = wr_en_i && (m_q.size() < DEPTH);
        if (m_std) begin
            if (rd_en_i && m_q.size() > 0) m_out = m_q.pop_front();
        end else begin
            take = rd_en_i && m_ov;
            load = (m_q.size() > 0) && (!m_ov || take);
            if (load) begin
                m_out = m_q.pop_front();
                m_ov  = 1'b1;
            end else if (take) begin
                m_ov = 1'b0;
            end
        end
        if (push) m_q.push_back(wr_data_i);
    endtask

    task automatic do_reset(input bit std);
        @(negedge clk);
        rst_n = 1'b0;
        wr_en_i = 1'b0;
        rd_en_i = 1'b0;
        m_vld = 1'b0; m_std = 1'b1; m_q.delete(); m_out = '0; m_ov = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        mode_sel_i = std;
        wr_en_i = 1'b1;        // R1: write before the mode edge must be dropped
        wr_data_i = 32'hDEAD0001;
        check_outputs();
        chk(rd_data_o == '0, "R3 reset data", rd_data_o, 0);
        model_step();
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // One phase: probabilities in percent
    task automatic run(input int n, input int wr_pct, input int rd_pct);
        for (int i = 0; i < n; i++) begin
            check_outputs();
            wr_en_i    = ($urandom_range(99) < wr_pct);
            rd_en_i    = ($urandom_range(99) < rd_pct);
            wr_data_i  = $urandom();
            mode_sel_i = $urandom_range(1);   // R2: select pin toggled freely
            model_step();
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // R6: lone word into empty fall-through FIFO, directed timing
    task automatic lone_word();
        check_outputs();
        wr_en_i = 1'b1; rd_en_i = 1'b0; wr_data_i = 32'hA5A5_0042;
        model_step();
        @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0;
        chk(rd_stat_o == 1'b0, "R6 not ready after one edge", rd_stat_o, 0);
        model_step();
        @(posedge clk); @(negedge clk);
        chk(rd_stat_o == 1'b1, "R6 ready after two edges", rd_stat_o, 1);
        chk(rd_data_o == 32'hA5A5_0042, "R6 lone word", rd_data_o, 32'hA5A5_0042);
        run(3, 0, 0);
        rd_en_i = 1'b1;
        model_step();
        @(posedge clk); @(negedge clk);
        rd_en_i = 1'b0;
        chk(rd_stat_o == 1'b0, "R7 ready drops after last read", rd_stat_o, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Standard mode
        do_reset(1'b1);
        run(4, 0, 100);     // R9 reads while empty
        run(40, 100, 0);    // fill past full, R5 R9
        run(40, 0, 100);    // drain, R3 R4
        run(600, 55, 45);
        // Fall-through mode
        do_reset(1'b0);
        run(3, 0, 100);
        lone_word();
        run(45, 100, 0);    // R8 capacity DEPTH+1
        run(45, 0, 100);
        run(600, 50, 50);
        run(300, 70, 30);
        // Back to standard after reset
        do_reset(1'b1);
        run(400, 45, 55);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule